// File: doc/BRIEF.md
# Block-Transfer Synchronous Serial Shifter

This block is a clocked serial port that sends one bit and receives one bit per serial clock period. A single start command moves a programmed run of 1 to 256 bits, with no host help per byte. Transmit bytes are taken from a small local byte buffer, and received bytes are written back into the same locations as the run advances. The host fills the buffer, sets the run length, the bit order, the clock source and the divider, and pulses start. When the run ends, the done flag rises and the host reads the received bytes back from the buffer.

The serial clock is either made inside the block from a programmable divider, or taken from an external serial clock pin. An external clock is passed through a synchronizer, and its edges are then detected. The block changes outgoing data after a falling serial clock edge and samples incoming data on a rising edge. While the clock is idle it is high.

Top module: `ser_blk_shifter`

## Requirements
- R1: After reset, `busy` and `done` are 0, `sck_out` is 1, `sdo` is 0 and `sck_oe` is 1.
- R2: With the internal clock, `sck_out` idles high. During a run, each of its phases lasts `div_sel`+2 clock cycles, so the period is 2*(`div_sel`+2) cycles and the fastest period is 4 cycles.
- R3: A run carries N = `bit_cnt_m1`+1 bits, so 0 gives 1 bit and 255 gives 256 bits. With the internal clock, `sck_out` shows exactly N falling and N rising edges per run.
- R4: Transmitted bit j is taken from buffer byte j/8. With `lsb_first`=1 it is bit position j%8. With `lsb_first`=0 it is bit position 7-(j%8).
- R5: Received bit j is stored in buffer byte j/8, at the same bit position that R4 uses for transmission. In a final partial byte, the positions not reached are written as 0.
- R6: Buffer bytes at index N/8 rounded up and above keep their contents through a run.
- R7: Start clears `done` and raises `busy`. After the last rising serial edge, `busy` falls and `done` rises, and `done` stays at 1 until the next start.
- R8: With `ext_clk`=1 latched at start, `sck_oe` is 0 and the run follows the edges of `sck_in`. Each phase of `sck_in` must last at least 4 clock cycles. The first edge must come at least 3 cycles after start.
- R9: A host buffer write made while `busy` is 1 has no effect.
- R10: During a run, `sdo` changes only together with a falling serial clock edge, and `sdi` is captured on rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| lsb_first | input | 1 | 1: least significant bit first; 0: most significant bit first |
| ext_clk | input | 1 | 1: serial clock from `sck_in`; 0: internal divider |
| div_sel | input | 8 | Internal clock phase length minus 2, in cycles |
| bit_cnt_m1 | input | 8 | Run length minus one |
| host_we | input | 1 | Host buffer write strobe |
| host_addr | input | 5 | Host buffer byte address |
| host_wdata | input | 8 | Host buffer write data |
| host_rdata | output | 8 | Host buffer read data, one cycle after the address |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Internal serial clock output |
| sck_oe | output | 1 | Drive enable for `sck_out` |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |

## Verification
Runs are made with both clock sources and both bit orders. Run lengths include 1 bit, exactly one byte, a partial last byte and the full 256 bits, and the internal divider is taken from its fastest setting upward. A model device on the serial pins supplies random receive bits and records what is sent. A swapped bit order therefore shows up as a transmit mismatch, and a wrong byte boundary shows up as wrong or clobbered buffer bytes. Edge counts and measured periods separate an off-by-one in the run length from an off-by-one in the divider. A host write issued in the middle of a run shows whether the buffer is guarded while busy.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_RUN,
    ST_FLUSH
  } ssb_state_t;

  // bit position inside a byte for the j-th bit of that byte
  function automatic logic [2:0] ssb_bit_pos(input logic lsb, input logic [2:0] j);
    return lsb ? j : (3'd7 - j);
  endfunction
endpackage

// File: rtl/ssb_clkgen.sv
module ssb_clkgen #(
  parameter int DIV_W = 8,
  localparam int CW = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ext_mode,
  input  logic [DIV_W-1:0] div_val,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] half_m1;
  logic          sck_q;
  logic          s1, s2, s3;
  logic          tick;

  assign half_m1 = {1'b0, div_val} + CW'(1);
  assign tick    = run && !ext_mode && (cnt == half_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sck_q <= 1'b1;
    end else if (!run || ext_mode) begin
      cnt   <= '0;
      sck_q <= 1'b1;
    end else if (tick) begin
      cnt   <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= sck_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise_ev = (tick && !sck_q) || (run && ext_mode && s2 && !s3);
  assign fall_ev = (tick && sck_q)  || (run && ext_mode && !s2 && s3);
  assign sck_out = sck_q;

  assert_one_edge_R2: assert property (@(posedge clk) disable iff (rst)
    !(rise_ev && fall_ev));

  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (run && !ext_mode) |-> (cnt <= half_m1));

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> sck_q);
endmodule

// File: rtl/ssb_buffer.sv
module ssb_buffer #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ssb_engine.sv
module ssb_engine
  import ssb_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             lsb,
  input  logic [CNT_W-1:0] bits_m1,
  input  logic             rise_ev,
  input  logic             fall_ev,
  input  logic             sdi,
  input  logic [7:0]       mem_rdata,
  output logic [AW-1:0]    mem_raddr,
  output logic             mem_we,
  output logic [AW-1:0]    mem_waddr,
  output logic [7:0]       mem_wdata,
  output logic             run,
  output logic             busy,
  output logic             done,
  output logic             sdo
);
  ssb_state_t       st;
  logic [CNT_W-1:0] bitcnt;
  logic [AW-1:0]    byte_idx;
  logic [7:0]       txbyte, rxbyte, tx_src;
  logic             wb_pend, ld_pend, sdo_q, done_q;
  logic [2:0]       pos_now;

  assign pos_now   = ssb_bit_pos(lsb, bitcnt[2:0]);
  assign tx_src    = ld_pend ? mem_rdata : txbyte;
  assign mem_raddr = (st == ST_FETCH) ? byte_idx : byte_idx + AW'(1);
  assign mem_we    = ((st == ST_RUN) && wb_pend) || (st == ST_FLUSH);
  assign mem_waddr = byte_idx;
  assign mem_wdata = rxbyte;
  assign run       = (st == ST_RUN);
  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign sdo       = sdo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      byte_idx <= '0;
      txbyte   <= '0;
      rxbyte   <= '0;
      wb_pend  <= 1'b0;
      ld_pend  <= 1'b0;
      sdo_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st       <= ST_FETCH;
          done_q   <= 1'b0;
          bitcnt   <= '0;
          byte_idx <= '0;
          rxbyte   <= '0;
          wb_pend  <= 1'b0;
          ld_pend  <= 1'b0;
        end
        ST_FETCH: st <= ST_LOAD;
        ST_LOAD: begin
          txbyte <= mem_rdata;
          sdo_q  <= mem_rdata[pos_now];
          st     <= ST_RUN;
        end
        ST_RUN: begin
          if (ld_pend) begin
            txbyte  <= mem_rdata;
            rxbyte  <= '0;
            ld_pend <= 1'b0;
          end
          if (wb_pend) begin
            wb_pend  <= 1'b0;
            ld_pend  <= 1'b1;
            byte_idx <= byte_idx + AW'(1);
          end
          if (fall_ev) sdo_q <= tx_src[pos_now];
          if (rise_ev) begin
            rxbyte[pos_now] <= sdi;
            if (bitcnt == bits_m1) begin
              st <= ST_FLUSH;
            end else begin
              bitcnt <= bitcnt + CNT_W'(1);
              if (&bitcnt[2:0]) wb_pend <= 1'b1;
            end
          end
        end
        ST_FLUSH: begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_sdo_on_fall_R10: assert property (@(posedge clk) disable iff (rst)
    (($past(st) == ST_RUN) && (sdo_q != $past(sdo_q))) |-> $past(fall_ev));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bitcnt <= bits_m1));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy);

  assert_fetch_follows_write_R5: assert property (@(posedge clk) disable iff (rst)
    (wb_pend && run) |=> ld_pend);
endmodule

// File: rtl/ser_blk_shifter.sv
module ser_blk_shifter #(
  parameter int MAX_BITS = 256,
  parameter int DIV_W    = 8,
  localparam int CNT_W   = $clog2(MAX_BITS),
  localparam int DEPTH   = (MAX_BITS + 7) / 8,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             lsb_first,
  input  logic             ext_clk,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [CNT_W-1:0] bit_cnt_m1,
  input  logic             host_we,
  input  logic [AW-1:0]    host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             sck_oe,
  input  logic             sdi,
  output logic             sdo,
  output logic             busy,
  output logic             done
);
  logic             lsb_q, ext_q, oe_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] bits_q;
  logic             run, rise_ev, fall_ev;
  logic [AW-1:0]    eng_raddr, eng_waddr, mem_raddr, mem_waddr;
  logic             eng_we, mem_we;
  logic [7:0]       eng_wdata, mem_wdata, mem_rdata;

  // configuration follows the inputs while idle, frozen during a run
  always_ff @(posedge clk) begin
    if (rst) begin
      lsb_q  <= 1'b1;
      ext_q  <= 1'b0;
      oe_q   <= 1'b1;
      div_q  <= '0;
      bits_q <= '0;
    end else if (!busy) begin
      lsb_q  <= lsb_first;
      ext_q  <= ext_clk;
      oe_q   <= ~ext_clk;
      div_q  <= div_sel;
      bits_q <= bit_cnt_m1;
    end
  end

  assign mem_we     = busy ? eng_we    : host_we;
  assign mem_waddr  = busy ? eng_waddr : host_addr;
  assign mem_wdata  = busy ? eng_wdata : host_wdata;
  assign mem_raddr  = busy ? eng_raddr : host_addr;
  assign host_rdata = mem_rdata;
  assign sck_oe     = oe_q;

  ssb_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst(rst), .run(run), .ext_mode(ext_q), .div_val(div_q),
    .sck_in(sck_in), .sck_out(sck_out), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  ssb_buffer #(.DEPTH(DEPTH), .DW(8)) u_buffer (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  ssb_engine #(.CNT_W(CNT_W), .AW(AW)) u_engine (
    .clk(clk), .rst(rst), .start(start), .lsb(lsb_q), .bits_m1(bits_q),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .sdi(sdi), .mem_rdata(mem_rdata),
    .mem_raddr(eng_raddr), .mem_we(eng_we), .mem_waddr(eng_waddr),
    .mem_wdata(eng_wdata), .run(run), .busy(busy), .done(done), .sdo(sdo)
  );

  assert_ext_release_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && ext_clk) |=> !sck_oe);

  assert_busy_needs_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

// File: tb/ser_blk_shifter_bench.sv
module ser_blk_shifter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 256;
  localparam int DEPTH = 32;
  localparam int AW = 5;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, lsb_first = 1'b1, ext_clk = 1'b0;
  logic [7:0] div_sel = '0, bit_cnt_m1 = '0;
  logic host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  wire  [7:0] host_rdata;
  logic sck_in = 1'b1, sdi = 1'b0;
  wire  sck_out, sck_oe, sdo, busy, done;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] txb [DEPTH];
  bit slv [NB];
  bit mo  [NB];
  bit mon_en = 0;
  int nfall = 0, nrise = 0, t_f0 = 0, t_f1 = 0, cyc = 0, r10_bad = 0;
  logic prev_sck = 1'b1, prev_sdo = 1'b0;

  ser_blk_shifter u_ser_blk_shifter (
    .clk(clk), .rst(rst), .start(start), .lsb_first(lsb_first), .ext_clk(ext_clk),
    .div_sel(div_sel), .bit_cnt_m1(bit_cnt_m1), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // model device on the internal clock: drives on falls, captures on rises
  always @(negedge clk) begin
    bit fell;
    cyc++;
    fell = prev_sck && !sck_out;
    if (mon_en) begin
      if (fell) begin
        if (nfall < NB) sdi = slv[nfall];
        if (nfall == 0) t_f0 = cyc;
        if (nfall == 1) t_f1 = cyc;
        nfall++;
      end
      if (!prev_sck && sck_out) begin
        if (nrise < NB) mo[nrise] = sdo;
        nrise++;
      end
      if (nfall > 0 && sdo != prev_sdo && !fell) r10_bad++;
    end
    prev_sck = sck_out;
    prev_sdo = sdo;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic host_write(input int a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input int a, output logic [7:0] d);
    @(negedge clk);
    host_addr = AW'(a);
    @(negedge clk);
    d = host_rdata;
  endtask

  function automatic int bpos(input bit lsb, input int k);
    return lsb ? k : 7 - k;
  endfunction

  function automatic logic [7:0] exp_rx(input bit lsb, input int b, input int n);
    logic [7:0] r = '0;
    for (int k = 0; k < 8; k++) begin
      int j = b * 8 + k;
      r[bpos(lsb, k)] = (j < n) ? slv[j] : 1'b0;
    end
    return r;
  endfunction

  task automatic run_xfer(input bit ext, input bit lsb, input int dv, input int nm1);
    int n, nbytes, bad_tx, bad_rx, bad_keep, waited;
    logic [7:0] rd;
    n = nm1 + 1;
    nbytes = (n + 7) / 8;
    for (int a = 0; a < DEPTH; a++) begin
      txb[a] = 8'($urandom);
      host_write(a, txb[a]);
    end
    for (int j = 0; j < NB; j++) slv[j] = 1'($urandom);
    nfall = 0; nrise = 0; t_f0 = 0; t_f1 = 0; r10_bad = 0;
    @(negedge clk);
    lsb_first = lsb; ext_clk = ext; div_sel = 8'(dv); bit_cnt_m1 = 8'(nm1);
    start = 1'b1;
    mon_en = !ext;
    @(negedge clk);
    start = 1'b0;
    chk("R7", "done after start", done, 0);
    chk("R7", "busy after start", busy, 1);
    if (ext) begin
      repeat (3) @(negedge clk);
      chk("R8", "clock pin released", sck_oe, 0);
      for (int j = 0; j < n; j++) begin
        sck_in = 1'b0; sdi = slv[j];
        repeat (4) @(negedge clk);
        mo[j] = sdo;
        sck_in = 1'b1;
        repeat (4) @(negedge clk);
      end
    end else begin
      host_write(31, ~txb[31]); // R9: must be ignored, busy is high here
    end
    waited = 0;
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    mon_en = 0;
    chk("R7", "done at end", done, 1);
    chk("R7", "busy at end", busy, 0);
    if (!ext) begin
      chk("R3", "falling edges", nfall, n);
      chk("R3", "rising edges", nrise, n);
      if (n >= 2) chk("R2", "clock period", t_f1 - t_f0, 2 * (dv + 2));
      chk("R10", "sdo moves away from falls", r10_bad, 0);
    end
    bad_tx = 0;
    for (int j = 0; j < n; j++)
      if (mo[j] != txb[j / 8][bpos(lsb, j % 8)]) bad_tx++;
    chk("R4", "transmit bit mismatches", bad_tx, 0);
    bad_rx = 0; bad_keep = 0;
    for (int b = 0; b < DEPTH; b++) begin
      host_read(b, rd);
      if (b < nbytes) begin
        if (rd != exp_rx(lsb, b, n)) bad_rx++;
      end else if (rd != txb[b]) bad_keep++;
    end
    chk("R5", "received byte mismatches", bad_rx, 0);
    chk("R6", "untouched byte changes", bad_keep, 0);
    if (!ext && nbytes < DEPTH) begin
      host_read(31, rd);
      chk("R9", "write while busy ignored", rd, txb[31]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy at reset", busy, 0);
    chk("R1", "done at reset", done, 0);
    chk("R1", "sck_out at reset", sck_out, 1);
    chk("R1", "sdo at reset", sdo, 0);
    chk("R1", "sck_oe at reset", sck_oe, 1);
    // directed corners
    run_xfer(1'b0, 1'b1, 0, 7);    // one byte, fastest clock
    run_xfer(1'b0, 1'b0, 3, 0);    // single bit
    run_xfer(1'b0, 1'b1, 0, 255);  // full 256 bits
    run_xfer(1'b0, 1'b0, 1, 12);   // partial last byte, MSB first
    run_xfer(1'b1, 1'b1, 0, 19);   // external clock, LSB first
    run_xfer(1'b1, 1'b0, 0, 8);    // external clock, 9 bits MSB first
    // random mix
    for (int t = 0; t < 6; t++)
      run_xfer(1'($urandom), 1'($urandom), int'($urandom % 6), int'($urandom % 256));
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule